// File: doc/BRIEF.md
# Reference-Clock Power Mode Controller

This block decides when a serial link's PLL and serial I/O may run, and when parallel data may be captured. A two-bit mode select turns the link on or off. A slow reference clock is oversampled by a free-running fast clock so that the block notices when the reference stops toggling. The analog PLL is not modelled. Lock is treated as a fixed count of reference rising edges, and the ready flag asserts once that count is reached.

There are two ways to power down, and they cost different amounts to leave. A zero mode select is a full shutdown: everything is off, including the internal references, and waking needs the long `COLD_WAIT` count. A stalled reference clock is a light idle: the PLL and serial I/O stop, but the references stay on. The first reference transition after a stall restarts the link, and waking from idle needs only the shorter `WARM_WAIT` count. No mode change is needed to leave idle.

Top module: `refclk_pwr_ctrl`

## Requirements
- R1: While `mode_sel_i` is 2'b00, the block is in full power-down from the next cycle on. In that state `pll_en_o`, `sio_en_o`, `refs_on_o` and `ready_o` are all 0, whether or not the reference toggles, and whatever state the block was in before.
- R2: Leaving full power-down needs two things: a nonzero `mode_sel_i` and a transition on `ref_clk_i`. With a nonzero mode and a static reference, all outputs stay 0.
- R3: From the wake until the next power-down, `pll_en_o`, `sio_en_o` and `refs_on_o` are all 1.
- R4: After a wake from full power-down, `ready_o` stays 0 until `COLD_WAIT` rising reference edges have been counted after the waking transition. It then asserts.
- R5: If `ref_clk_i` makes no transition for `STALL_CYCLES` fast-clock cycles, measured after a two-stage synchronizer, the block enters idle. In idle `pll_en_o`, `sio_en_o` and `ready_o` are 0 and `refs_on_o` stays 1. This holds whether the reference is stuck high or stuck low.
- R6: In idle, the first reference transition of either polarity sets `pll_en_o` and `sio_en_o` back to 1, with no change to the mode select.
- R7: After a wake from idle, `ready_o` asserts once `WARM_WAIT` rising reference edges have been counted after the waking transition. `WARM_WAIT` must be smaller than `COLD_WAIT`; this is checked at elaboration.
- R8: `ready_o` drops in the same cycle that a zero mode select or a stall is detected. That is one cycle before `pll_en_o` drops.
- R9: A stall during a lock wait also sends the block to idle. The wake that follows then uses the `WARM_WAIT` count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous to `clk` |
| mode_sel_i | input | 2 | Mode select; 2'b00 means full power-down |
| pll_en_o | output | 1 | PLL enable |
| sio_en_o | output | 1 | Serial I/O enable |
| refs_on_o | output | 1 | Internal references powered |
| ready_o | output | 1 | Parallel data may be captured |

## Verification
The bench builds the block with `STALL_CYCLES`=16, `COLD_WAIT`=20 and `WARM_WAIT`=6 instead of the large defaults. With these values, many complete wake and lock sequences fit into a short run. The reference half-period is drawn between 3 and 5 fast cycles, which keeps normal toggling well inside the stall window. With these values, the bench can hit the exact edge count of both relock waits and measure the stall delay to within a few cycles. It also covers stalls at both levels, a stall during a lock wait, and randomly mixed sequences of the two power-down paths.

// File: rtl/refclk_pwr_pkg.sv
package refclk_pwr_pkg;
   typedef enum logic [2:0] {
      ST_OFF  = 3'd0,   // full power-down
      ST_COLD = 3'd1,   // long relock wait
      ST_RUN  = 3'd2,   // locked
      ST_IDLE = 3'd3,   // reference stalled, references kept on
      ST_WARM = 3'd4    // short relock wait
   } pwr_state_t;
endpackage

// File: rtl/refclk_edge_sync.sv
module refclk_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o,
   output logic any_o
);
   localparam int MSB = STAGES - 1;

   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("refclk_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], async_i};
         prev_q <= sh_q[MSB];
      end
   end

   assign rise_o = sh_q[MSB] & ~prev_q;
   assign any_o  = sh_q[MSB] ^ prev_q;
endmodule

// File: rtl/refclk_stall_mon.sv
module refclk_stall_mon #(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_i,
   output logic stalled_o
);
   localparam int SW = $clog2(LIMIT + 1);
   localparam logic [SW-1:0] LIM = SW'(LIMIT);

   logic [SW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (edge_i)        cnt_q <= '0;
      else if (cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;
   end

   assign stalled_o = (cnt_q == LIM);
endmodule

// File: rtl/refclk_lock_cnt.sv
module refclk_lock_cnt #(
   parameter int COLD_WAIT = 2048,
   parameter int WARM_WAIT = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic warm_i,
   input  logic tick_i,
   output logic done_o
);
   localparam int CW = $clog2(COLD_WAIT + 1);
   localparam logic [CW-1:0] COLD_T = CW'(COLD_WAIT);
   localparam logic [CW-1:0] WARM_T = CW'(WARM_WAIT);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] tgt;

   assign tgt = warm_i ? WARM_T : COLD_T;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (clear_i)              cnt_q <= '0;
      else if (tick_i && cnt_q != tgt) cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = (cnt_q == tgt);
endmodule

// File: rtl/refclk_pwr_ctrl.sv
module refclk_pwr_ctrl
   import refclk_pwr_pkg::*;
#(
   parameter int STALL_CYCLES = 64,
   parameter int COLD_WAIT    = 2048,
   parameter int WARM_WAIT    = 256,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_clk_i,
   input  logic [1:0] mode_sel_i,
   output logic       pll_en_o,
   output logic       sio_en_o,
   output logic       refs_on_o,
   output logic       ready_o
);
   generate
      if (WARM_WAIT >= COLD_WAIT) begin : g_bad_wait
         $error("refclk_pwr_ctrl: WARM_WAIT must be below COLD_WAIT");
      end
      if (WARM_WAIT < 1 || STALL_CYCLES < 4) begin : g_bad_min
         $error("refclk_pwr_ctrl: WARM_WAIT >= 1 and STALL_CYCLES >= 4 required");
      end
   endgenerate

   logic       ref_rise, ref_any, stalled, lock_done, mode_on, in_lock;
   pwr_state_t state_q, state_d;

   refclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(ref_clk_i),
      .rise_o(ref_rise), .any_o(ref_any)
   );

   refclk_stall_mon #(.LIMIT(STALL_CYCLES)) u_stall (
      .clk(clk), .rst_n(rst_n), .edge_i(ref_any), .stalled_o(stalled)
   );

   assign in_lock = (state_q == ST_COLD) || (state_q == ST_WARM);

   refclk_lock_cnt #(.COLD_WAIT(COLD_WAIT), .WARM_WAIT(WARM_WAIT)) u_lock (
      .clk(clk), .rst_n(rst_n), .clear_i(!in_lock),
      .warm_i(state_q == ST_WARM), .tick_i(ref_rise), .done_o(lock_done)
   );

   assign mode_on = |mode_sel_i;

   always_comb begin
      state_d = state_q;
      if (!mode_on) begin
         state_d = ST_OFF;
      end else begin
         unique case (state_q)
            ST_OFF:  if (ref_any) state_d = ST_COLD;
            ST_COLD,
            ST_WARM: if (stalled) state_d = ST_IDLE;
                     else if (lock_done) state_d = ST_RUN;
            ST_RUN:  if (stalled) state_d = ST_IDLE;
            ST_IDLE: if (ref_any) state_d = ST_WARM;
            default: state_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_OFF;
      else        state_q <= state_d;
   end

   assign pll_en_o  = in_lock || (state_q == ST_RUN);
   assign sio_en_o  = pll_en_o;
   assign refs_on_o = (state_q != ST_OFF);
   assign ready_o   = (state_q == ST_RUN) && mode_on && !stalled;
endmodule

// File: rtl/refclk_pwr_chk.sv
module refclk_pwr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_sel_i,
   input logic       pll_en_o,
   input logic       sio_en_o,
   input logic       refs_on_o,
   input logic       ready_o
);
   // R1
   off_after_zero_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel_i == 2'b00) |=> (!pll_en_o && !sio_en_o && !refs_on_o));

   // R8
   ready_low_in_zero_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel_i == 2'b00) |-> !ready_o);

   // R3
   refs_cover_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_en_o || sio_en_o) |-> refs_on_o);

   // R4
   ready_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> $past(pll_en_o));

   // R8
   ready_falls_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready_o) |-> pll_en_o);

   // R7
   idle_not_ready_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (refs_on_o && !pll_en_o && mode_sel_i != 2'b00) |=> !ready_o);
endmodule

bind refclk_pwr_ctrl refclk_pwr_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mode_sel_i(mode_sel_i),
   .pll_en_o(pll_en_o), .sio_en_o(sio_en_o),
   .refs_on_o(refs_on_o), .ready_o(ready_o)
);

// File: tb/tb_refclk_pwr_ctrl.sv
module tb_refclk_pwr_ctrl;
   localparam int STALL = 16;
   localparam int COLD  = 20;
   localparam int WARM  = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_clk = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       pll_en, sio_en, refs_on, ready;
   int         total = 0;
   int         bad = 0;
   bit         finished = 1'b0;

   always #5 clk = ~clk;

   refclk_pwr_ctrl #(.STALL_CYCLES(STALL), .COLD_WAIT(COLD), .WARM_WAIT(WARM)) dut (
      .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .mode_sel_i(mode),
      .pll_en_o(pll_en), .sio_en_o(sio_en), .refs_on_o(refs_on), .ready_o(ready)
   );

   function automatic int exp_wait(bit warm);
      return warm ? WARM : COLD;
   endfunction

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic ref_cycles(int n, int h);
      for (int i = 0; i < n; i++) begin
         ref_clk = 1'b1; tick(h);
         ref_clk = 1'b0; tick(h);
      end
   endtask

   task automatic outs(output int v);
      @(negedge clk);
      v = {pll_en, sio_en, refs_on, ready};
   endtask

   task automatic lock_finish(bit warm, int h, string req);
      int v;
      ref_cycles(exp_wait(warm) - 1, h);
      outs(v); check({req, " ready low one edge early"}, v & 1, 0);
      ref_cycles(1, h);
      outs(v); check({req, " ready after full wait"}, v, 4'b1111);
   endtask

   task automatic cold_wake(int h);
      int v;
      ref_cycles(1, h);
      outs(v); check("R3 enables on after wake", v, 4'b1110);
      lock_finish(1'b0, h, "R4");
   endtask

   task automatic warm_wake(int h, string req);
      int v;
      ref_clk = ~ref_clk; tick(h);
      outs(v); check("R6 first transition re-enables", v, 4'b1110);
      if (ref_clk) begin ref_clk = 1'b0; tick(h); end
      lock_finish(1'b1, h, req);
   endtask

   task automatic stall_path(bit lvl, int h);
      int k = 0;
      int v;
      if (ref_clk == lvl) begin ref_clk = ~lvl; tick(h); end
      ref_clk = lvl;
      @(negedge clk);
      while (ready && k < 60) begin @(negedge clk); k++; end
      check("R5 stall delay in window", (k >= STALL && k <= STALL + 6) ? 1 : 0, 1);
      check("R8 ready drops before pll_en", pll_en, 1);
      outs(v); check("R5 idle outputs", v, 4'b0010);
      tick(1);
   endtask

   task automatic mode0_path(int h);
      int v;
      tick(1);
      mode = 2'b00;
      @(negedge clk);
      check("R8 ready drops with mode zero", {pll_en, ready}, 2'b10);
      outs(v); check("R1 outputs off after mode zero", v, 0);
      ref_cycles(4, h);
      outs(v); check("R1 toggling ignored in power-down", v, 0);
   endtask

   initial begin
      int v;
      void'($urandom(32'h5eed_0042));
      tick(5);
      rst_n = 1'b1;
      tick(2);
      outs(v); check("R1 reset state", v, 0);
      tick(1);

      // R2: nonzero mode, static reference
      mode = 2'b10;
      tick(40);
      outs(v); check("R2 static reference keeps off", v, 0);
      tick(1);

      cold_wake(4);
      stall_path(1'b1, 4);
      warm_wake(4, "R7");
      stall_path(1'b0, 3);
      warm_wake(3, "R7");

      // R9: stall inside a cold lock wait
      mode0_path(4);
      mode = 2'b01;
      ref_cycles(4, 4);
      ref_clk = 1'b1;
      tick(STALL + 10);
      outs(v); check("R9 stall during lock gives idle", v, 4'b0010);
      warm_wake(4, "R9");

      for (int it = 0; it < 8; it++) begin
         int  h    = $urandom_range(5, 3);
         bit  warm = 1'($urandom_range(1, 0));
         bit  lvl  = 1'($urandom_range(1, 0));
         mode = 2'($urandom_range(3, 1));
         if (warm) begin
            stall_path(lvl, h);
            warm_wake(h, "R7");
         end else begin
            mode0_path(h);
            mode = 2'($urandom_range(3, 1));
            cold_wake(h);
         end
      end

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule